// File: doc/BRIEF.md
# Odd-Ratio Symmetric Clock Divider

This block takes a fast input clock and produces a slower clock whose period is an odd whole number of input periods, fixed when the design is elaborated. The output spends exactly half of each period high and half low, even though an odd ratio cannot be split evenly on one clock edge alone.

A counter on the rising edge of the input clock forms a first wave that is high for n input periods out of 2n+1. A register on the falling edge follows that wave half an input period later. The output is the OR of the two, so it is high for n+0.5 input periods. An active-low asynchronous reset holds everything low. A ratio that is even or below 3 stops elaboration.

Top module: `odd_div_clk`

## Requirements
- R1: The internal counter advances by one on each rising input-clock edge and returns to 0 after reaching RATIO-1, so its cycle is RATIO edges long.
- R2: The rising-edge wave goes high on the rising edge where the counter holds n = (RATIO-1)/2 and low on the rising edge where it holds RATIO-1, so it is high for n input periods in every cycle.
- R3: The falling-edge wave takes the value of the rising-edge wave on every falling input-clock edge, which delays it by half an input period.
- R4: The output `clk_o` is the OR of the two waves, and its rising edges are RATIO input periods apart.
- R5: `clk_o` stays high for n+0.5 input periods in each cycle, which is a 50% duty cycle.
- R6: While `rst_ni` is 0, the counter and both waves are cleared at once and `clk_o` is 0. After reset is released, the first rising edge of `clk_o` follows the (n+1)-th rising input-clock edge.
- R7: A RATIO parameter that is even or less than 3 makes elaboration fail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock. Both of its edges are used. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_o | output | 1 | Divided clock with 50% duty cycle |

## Verification
The bench builds four copies of the divider, with RATIO set to 3, 5, 9 and 11, and drives them all from the same clock and reset. RATIO 3 is the smallest case, where each wave is high for a single input period and the output for one and a half. RATIO 9 is the divide-by-nine case. RATIO 11 uses a four-bit counter that never reaches its top codes, which tests the wrap point away from a power of two. In every copy the bench times the output's high phase and its rise-to-rise interval, checks when the first rise comes after reset, and checks the output when reset is asserted again in the middle of a run.

// File: rtl/odd_div_pkg.sv
`timescale 1ns/1ps
package odd_div_pkg;

   // True when a divide ratio is legal for this block (R7).
   function automatic bit ratio_ok(input int unsigned r);
      return (r >= 3) && (r % 2 == 1);
   endfunction

   // n in RATIO = 2n+1
   function automatic int unsigned half_of(input int unsigned r);
      return (r - 1) / 2;
   endfunction

   // Counter width that holds 0..r-1
   function automatic int unsigned cnt_width(input int unsigned r);
      return (r <= 2) ? 1 : $clog2(r);
   endfunction

endpackage

// File: rtl/odd_div_counter.sv
`timescale 1ns/1ps
// Modulo-RATIO counter clocked on the rising edge (R1).
module odd_div_counter #(
   parameter int unsigned RATIO = 9,
   parameter int unsigned CW    = odd_div_pkg::cnt_width(RATIO)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/odd_div_rise_wave.sv
`timescale 1ns/1ps
// Rising-edge wave: set at count n, cleared at count RATIO-1 (R2).
module odd_div_rise_wave #(
   parameter int unsigned RATIO = 9,
   parameter int unsigned CW    = odd_div_pkg::cnt_width(RATIO)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] cnt_i,
   output logic          wave_o
);
   localparam logic [CW-1:0] SET_AT = CW'(odd_div_pkg::half_of(RATIO));
   localparam logic [CW-1:0] CLR_AT = CW'(RATIO - 1);

   logic wave_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              wave_q <= 1'b0;
      else if (cnt_i == SET_AT) wave_q <= 1'b1;
      else if (cnt_i == CLR_AT) wave_q <= 1'b0;
   end

   assign wave_o = wave_q;
endmodule

// File: rtl/odd_div_fall_wave.sv
`timescale 1ns/1ps
// Falling-edge copy of the rising-edge wave, half an input period late (R3).
module odd_div_fall_wave (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wave_i,
   output logic wave_o
);
   logic wave_q;

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wave_q <= 1'b0;
      else         wave_q <= wave_i;
   end

   assign wave_o = wave_q;
endmodule

// File: rtl/odd_div_clk.sv
`timescale 1ns/1ps
// Odd-ratio clock divider with 50% duty cycle.
module odd_div_clk #(
   parameter int unsigned RATIO = 9
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic clk_o
);
   localparam int unsigned CW = odd_div_pkg::cnt_width(RATIO);

   // R7: reject even ratios and ratios below 3
   generate
      if (!odd_div_pkg::ratio_ok(RATIO)) begin : g_bad_ratio
         $fatal(1, "odd_div_clk: RATIO must be odd and at least 3");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          wave_r;
   logic          wave_f;

   odd_div_counter #(.RATIO(RATIO), .CW(CW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_o  (cnt_q)
   );

   odd_div_rise_wave #(.RATIO(RATIO), .CW(CW)) u_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt_q),
      .wave_o (wave_r)
   );

   odd_div_fall_wave u_fall (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wave_i (wave_r),
      .wave_o (wave_f)
   );

   // R4/R5: OR of the two waves widens the high phase by half a period
   assign clk_o = wave_r | wave_f;
endmodule

// File: rtl/odd_div_clk_chk.sv
`timescale 1ns/1ps
module odd_div_clk_chk #(
   parameter int unsigned RATIO = 9,
   parameter int unsigned CW    = odd_div_pkg::cnt_width(RATIO)
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [CW-1:0] cnt,
   input logic          wave_r,
   input logic          wave_f,
   input logic          clk_o
);
   localparam logic [CW-1:0] LAST  = CW'(RATIO - 1);
   localparam logic [CW-1:0] AFTER = CW'(odd_div_pkg::half_of(RATIO) + 1);

   p_cnt_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt == LAST) |=> (cnt == '0));

   p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

   p_rise_point_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wave_r) |-> (cnt == AFTER));

   p_fall_point_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wave_r) |-> (cnt == '0));

   p_half_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wave_f == wave_r);

   p_reset_low_r6: assert property (@(posedge clk_i)
      !rst_ni |-> !clk_o);
endmodule

bind odd_div_clk odd_div_clk_chk #(.RATIO(RATIO)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .cnt    (cnt_q),
   .wave_r (wave_r),
   .wave_f (wave_f),
   .clk_o  (clk_o)
);

// File: tb/odd_div_clk_tb_top.sv
`timescale 1ns/1ps
module odd_div_clk_tb_top;
   localparam realtime TCLK = 10.0;
   localparam int      ITEMS = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   finished = 0;

   always #(TCLK/2) clk = ~clk;

   function automatic int ratio_at(input int i);
      case (i)
         0: return 3;
         1: return 5;
         2: return 9;
         default: return 11;
      endcase
   endfunction

   task automatic chk_real(input string tag, input real act, input real exp);
      n_cmp++;
      if ((act - exp > 0.01) || (exp - act > 0.01)) begin
         n_bad++;
         $display("FAIL %s: actual %0.3f expected %0.3f", tag, act, exp);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   typedef struct {
      real period;
      real high;
   } exp_t;

   for (genvar g = 0; g < 4; g++) begin : lane
      localparam int R = ratio_at(g);
      localparam int N = (R - 1) / 2;

      logic    clk_div;
      exp_t    q[$];
      bit      done = 0;
      bit      got_first = 0;
      bit      seen_fall = 0;
      int      edges = 0;
      realtime t_rise = 0;
      real     t_high = 0;

      odd_div_clk #(.RATIO(R)) dut_i (
         .clk_i  (clk),
         .rst_ni (rst_n),
         .clk_o  (clk_div)
      );

      // driver: reset checks, then expected items into the scoreboard
      initial begin
         #25;
         chk_int($sformatf("R6 low in reset ratio %0d", R), int'(clk_div), 0);
         wait (rst_n);
         for (int k = 0; k < ITEMS; k++) begin
            exp_t e;
            e.period = R * TCLK;
            e.high   = (N + 0.5) * TCLK;
            q.push_back(e);
         end
         wait (q.size() == 0);
         done = 1;
         wait (!rst_n);
         #1;
         chk_int($sformatf("R6 low after mid-run reset ratio %0d", R), int'(clk_div), 0);
      end

      always @(posedge clk) if (rst_n) edges++;

      // monitor
      always @(posedge clk_div) begin
         if (!got_first) begin
            got_first = 1;
            chk_int($sformatf("R6 first rise edge ratio %0d", R), edges, N + 1);
         end else if (seen_fall && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk_real($sformatf("R1 R4 period ratio %0d", R), real'($realtime - t_rise), e.period);
            chk_real($sformatf("R2 R3 R5 high time ratio %0d", R), t_high, e.high);
         end
         t_rise    = $realtime;
         seen_fall = 0;
      end

      always @(negedge clk_div) begin
         if (got_first) begin
            t_high    = real'($realtime - t_rise);
            seen_fall = 1;
         end
      end
   end

   initial begin
      rst_n = 1'b0;
      #40;
      rst_n = 1'b1;
      wait (lane[0].done && lane[1].done && lane[2].done && lane[3].done);
      @(negedge clk);
      #2;
      rst_n = 1'b0;
      #20;
      summary();
   end

   initial begin
      #(200000 * TCLK);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule